// File: doc/BRIEF.md
# Accumulator Processor with Unified Word Memory

This block is a small stored-program processor built around one accumulator. Code and data share a single on-chip word memory. After a start pulse the processor works from address 1. For every instruction it latches the word at the program counter into an instruction register, advances the program counter, and then carries out the operation. It keeps going until it meets a halt or an opcode it does not recognise.

Each 24-bit instruction word holds an 8-bit opcode in bits 23:16 and a 16-bit operand in bits 15:0. The operand is used either as a memory address or as an immediate value. There are eleven opcodes. They cover loads, a store, addition and subtraction in memory and immediate forms, an unconditional jump, and jumps that are taken when the accumulator is zero or strictly positive. A second memory port lets the surrounding logic preload programs and data and read back results while the core is idle or halted.

Top module: `acc_proc`

## Requirements
- R1: After reset the accumulator reads 0, the program counter reads 1, and both `halted` and `illegal_op` read 0.
- R2: A start pulse taken while idle or halted sets the program counter to 1 and clears the accumulator, `halted` and `illegal_op`. Opcode 0 sets `halted`, which stays set until the next start. A start pulse taken while a program is running has no effect. The program counter stops one past the halt word.
- R3: Each instruction takes exactly four clock cycles: read the word at the program counter, latch it, increment the program counter, execute. A program whose k-th executed instruction is a halt raises `halted` exactly 4k cycles after the start edge.
- R4: The opcode sits in bits 23:16 and the operand in bits 15:0. Opcode 1 copies memory[operand] into the accumulator. Opcode 2 loads the operand zero-extended to 24 bits. Opcode 3 writes the accumulator to memory[operand].
- R5: Opcodes 4 and 6 add and subtract memory[operand]. Opcodes 5 and 7 add and subtract the zero-extended operand. All four wrap modulo 2^24.
- R6: Opcode 8 always loads the program counter with the operand. Opcode 9 does so only when the accumulator is zero. Opcode 10 does so only when the accumulator, read as two's complement, is greater than zero.
- R7: Opcodes 11 to 255 stop the processor with both `halted` and `illegal_op` set, and leave the accumulator unchanged. A later start clears `illegal_op`.
- R8: Memory addresses and jump targets use the operand modulo the memory depth, so operand 2448 reaches word 400 when the depth is 2048.
- R9: The host port writes memory when `hst_we` is high, and returns the word at `hst_addr` on `hst_rdata` one cycle later.
- R10: A repeated-addition multiply program that uses words 1000 to 1003 leaves the product of words 1000 and 1001 in word 1002.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin execution at address 1 (honoured when idle or halted) |
| hst_we | input | 1 | Host write enable |
| hst_addr | input | AW (11) | Host word address |
| hst_wdata | input | DW (24) | Host write data |
| hst_rdata | output | DW (24) | Host read data, one cycle after the address |
| halted | output | 1 | Processor stopped |
| illegal_op | output | 1 | Stop was caused by an unknown opcode |
| acc_out | output | DW (24) | Accumulator |
| pc_out | output | AW (11) | Program counter |

## Verification
The bench builds the block with its default parameters: 24-bit words, an 8-bit opcode and a 2048-word memory. Because the 16-bit operand is wider than the 11-bit address, operands above the memory depth can be written, and this is how the address wrap is exercised. The depth also covers the data words at 1000 to 1003 that the multiply program uses. Immediates up to 0xFFFF and subtractions that go below zero exercise zero extension, 24-bit wrap and the signed positive test. Exact cycle counts from start to halt pin down the four-cycle instruction sequence.

// File: rtl/acc_proc_pkg.sv
package acc_proc_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_FETCH,
    ST_LATCH,
    ST_INCR,
    ST_EXEC,
    ST_HALT
  } st_t;

  localparam int OP_HALT = 0;
  localparam int OP_LD   = 1;
  localparam int OP_LDI  = 2;
  localparam int OP_ST   = 3;
  localparam int OP_ADD  = 4;
  localparam int OP_ADDI = 5;
  localparam int OP_SUB  = 6;
  localparam int OP_SUBI = 7;
  localparam int OP_JMP  = 8;
  localparam int OP_JZ   = 9;
  localparam int OP_JGT  = 10;

endpackage

// File: rtl/acc_proc_mem.sv
module acc_proc_mem #(
  parameter int DW    = 24,
  parameter int DEPTH = 2048,
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic [AW-1:0] a_addr,
  input  logic          a_we,
  input  logic [DW-1:0] a_wdata,
  output logic [DW-1:0] a_rdata,
  input  logic [AW-1:0] b_addr,
  input  logic          b_we,
  input  logic [DW-1:0] b_wdata,
  output logic [DW-1:0] b_rdata
);

  logic [DW-1:0] ram [DEPTH];

  // Two ports, synchronous read. If both ports write the same word, port a wins.
  always_ff @(posedge clk) begin
    if (b_we) ram[b_addr] <= b_wdata;
    if (a_we) ram[a_addr] <= a_wdata;
    a_rdata <= ram[a_addr];
    b_rdata <= ram[b_addr];
  end

endmodule

// File: rtl/acc_proc_alu.sv
module acc_proc_alu #(
  parameter int DW    = 24,
  parameter int OPC_W = 8,
  parameter int ARG_W = DW - OPC_W
) (
  input  logic [OPC_W-1:0] opc,
  input  logic [ARG_W-1:0] arg,
  input  logic [DW-1:0]    acc,
  input  logic [DW-1:0]    mdata,
  output logic [DW-1:0]    acc_nxt,
  output logic             acc_we,
  output logic             take_jump,
  output logic             is_store,
  output logic             is_halt,
  output logic             is_illegal
);
  import acc_proc_pkg::*;

  logic [DW-1:0] imm;
  logic          acc_zero;
  logic          acc_pos;

  assign imm      = {{(DW-ARG_W){1'b0}}, arg};
  assign acc_zero = (acc == '0);
  assign acc_pos  = !acc[DW-1] && !acc_zero;

  always_comb begin
    acc_nxt    = acc;
    acc_we     = 1'b0;
    take_jump  = 1'b0;
    is_store   = 1'b0;
    is_halt    = 1'b0;
    is_illegal = 1'b0;
    case (opc)
      OPC_W'(OP_HALT): is_halt = 1'b1;
      OPC_W'(OP_LD):   begin acc_nxt = mdata;       acc_we = 1'b1; end
      OPC_W'(OP_LDI):  begin acc_nxt = imm;         acc_we = 1'b1; end
      OPC_W'(OP_ST):   is_store = 1'b1;
      OPC_W'(OP_ADD):  begin acc_nxt = acc + mdata; acc_we = 1'b1; end
      OPC_W'(OP_ADDI): begin acc_nxt = acc + imm;   acc_we = 1'b1; end
      OPC_W'(OP_SUB):  begin acc_nxt = acc - mdata; acc_we = 1'b1; end
      OPC_W'(OP_SUBI): begin acc_nxt = acc - imm;   acc_we = 1'b1; end
      OPC_W'(OP_JMP):  take_jump = 1'b1;
      OPC_W'(OP_JZ):   take_jump = acc_zero;
      OPC_W'(OP_JGT):  take_jump = acc_pos;
      default:         is_illegal = 1'b1;
    endcase
  end

endmodule

// File: rtl/acc_proc.sv
module acc_proc #(
  parameter int DW         = 24,
  parameter int OPC_W      = 8,
  parameter int DEPTH      = 2048,
  parameter int AW         = $clog2(DEPTH),
  parameter int START_ADDR = 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic          hst_we,
  input  logic [AW-1:0] hst_addr,
  input  logic [DW-1:0] hst_wdata,
  output logic [DW-1:0] hst_rdata,
  output logic          halted,
  output logic          illegal_op,
  output logic [DW-1:0] acc_out,
  output logic [AW-1:0] pc_out
);
  import acc_proc_pkg::*;

  localparam int ARG_W = DW - OPC_W;
  localparam logic [AW-1:0] PC_INIT = AW'(START_ADDR);

  st_t           st_q;
  logic [DW-1:0] ir_q;
  logic [AW-1:0] pc_q;
  logic [DW-1:0] acc_q;
  logic          halted_q;
  logic          illegal_q;

  logic [OPC_W-1:0] opc;
  logic [ARG_W-1:0] arg;
  logic [AW-1:0]    arg_addr;

  logic [AW-1:0] m_addr;
  logic          m_we;
  logic [DW-1:0] m_rdata;

  logic [DW-1:0] acc_nxt;
  logic          acc_we, take_jump, is_store, is_halt, is_illegal;
  logic          may_start;

  assign opc      = ir_q[DW-1 -: OPC_W];
  assign arg      = ir_q[ARG_W-1:0];
  assign arg_addr = arg[AW-1:0];

  // The word at the program counter is read during FETCH; at every other
  // time the port addresses the operand.
  assign m_addr    = (st_q == ST_FETCH) ? pc_q : arg_addr;
  assign m_we      = (st_q == ST_EXEC) && is_store;
  assign may_start = start && (st_q == ST_IDLE || st_q == ST_HALT);

  acc_proc_mem #(.DW(DW), .DEPTH(DEPTH), .AW(AW)) u_mem (
    .clk     (clk),
    .a_addr  (m_addr),
    .a_we    (m_we),
    .a_wdata (acc_q),
    .a_rdata (m_rdata),
    .b_addr  (hst_addr),
    .b_we    (hst_we),
    .b_wdata (hst_wdata),
    .b_rdata (hst_rdata)
  );

  acc_proc_alu #(.DW(DW), .OPC_W(OPC_W), .ARG_W(ARG_W)) u_alu (
    .opc        (opc),
    .arg        (arg),
    .acc        (acc_q),
    .mdata      (m_rdata),
    .acc_nxt    (acc_nxt),
    .acc_we     (acc_we),
    .take_jump  (take_jump),
    .is_store   (is_store),
    .is_halt    (is_halt),
    .is_illegal (is_illegal)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q      <= ST_IDLE;
      ir_q      <= '0;
      pc_q      <= PC_INIT;
      acc_q     <= '0;
      halted_q  <= 1'b0;
      illegal_q <= 1'b0;
    end else begin
      case (st_q)
        ST_IDLE, ST_HALT: begin
          if (may_start) begin
            pc_q      <= PC_INIT;
            acc_q     <= '0;
            halted_q  <= 1'b0;
            illegal_q <= 1'b0;
            st_q      <= ST_FETCH;
          end
        end
        ST_FETCH: st_q <= ST_LATCH;
        ST_LATCH: begin
          ir_q <= m_rdata;
          st_q <= ST_INCR;
        end
        ST_INCR: begin
          pc_q <= pc_q + 1'b1;
          st_q <= ST_EXEC;
        end
        ST_EXEC: begin
          if (is_illegal) begin
            halted_q  <= 1'b1;
            illegal_q <= 1'b1;
            st_q      <= ST_HALT;
          end else if (is_halt) begin
            halted_q <= 1'b1;
            st_q     <= ST_HALT;
          end else begin
            if (acc_we)    acc_q <= acc_nxt;
            if (take_jump) pc_q  <= arg_addr;
            st_q <= ST_FETCH;
          end
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign halted     = halted_q;
  assign illegal_op = illegal_q;
  assign acc_out    = acc_q;
  assign pc_out     = pc_q;

endmodule

// File: rtl/acc_proc_chk.sv
module acc_proc_chk #(
  parameter int DW = 24,
  parameter int AW = 11
) (
  input logic                clk,
  input logic                rst,
  input logic                start,
  input acc_proc_pkg::st_t   st,
  input logic [AW-1:0]       pc,
  input logic [DW-1:0]       acc,
  input logic                halted,
  input logic                illegal
);
  import acc_proc_pkg::*;

  // R1: reset puts the visible state at its initial values
  a_r1_reset_values: assert property (@(posedge clk)
    rst |=> (pc == AW'(1) && acc == '0 && !halted && !illegal));

  // R2: a taken start restarts from address 1 with clean flags
  a_r2_start_restart: assert property (@(posedge clk) disable iff (rst)
    (start && (st == ST_IDLE || st == ST_HALT)) |=>
      (pc == AW'(1) && acc == '0 && !halted && !illegal));

  // R2: halted state holds until a start
  a_r2_halt_holds: assert property (@(posedge clk) disable iff (rst)
    (halted && !start) |=> (halted && $stable(pc) && $stable(acc)));

  // R3: increment phase advances the program counter by one
  a_r3_pc_increments: assert property (@(posedge clk) disable iff (rst)
    (st == ST_INCR) |=> (pc == $past(pc) + 1'b1));

  // R4: the accumulator changes only in the execute phase or on a start
  a_r4_acc_only_in_exec: assert property (@(posedge clk) disable iff (rst)
    (st != ST_EXEC && !(start && (st == ST_IDLE || st == ST_HALT))) |=> $stable(acc));

  // R7: the illegal flag never stands without halted
  a_r7_illegal_halts: assert property (@(posedge clk) disable iff (rst)
    illegal |-> halted);

endmodule

bind acc_proc acc_proc_chk #(.DW(DW), .AW(AW)) u_chk (
  .clk     (clk),
  .rst     (rst),
  .start   (start),
  .st      (st_q),
  .pc      (pc_q),
  .acc     (acc_q),
  .halted  (halted_q),
  .illegal (illegal_q)
);

// File: tb/test_acc_proc.sv
module test_acc_proc;
  localparam int DW = 24;
  localparam int AW = 11;
  localparam int RUN_LIMIT = 20000;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          start = 1'b0;
  logic          hst_we = 1'b0;
  logic [AW-1:0] hst_addr = '0;
  logic [DW-1:0] hst_wdata = '0;
  logic [DW-1:0] hst_rdata;
  logic          halted, illegal_op;
  logic [DW-1:0] acc_out;
  logic [AW-1:0] pc_out;

  int n_checks = 0;
  int n_errors = 0;

  // Scoreboard queues: source 0 acc, 1 host data, 2 halted, 3 illegal, 4 pc, 9 bench value
  int            src_q[$];
  logic [DW-1:0] exp_q[$];
  logic [DW-1:0] act_q[$];
  string         tag_q[$];
  event          sample_ev;

  always #10 clk = ~clk;

  acc_proc i_acc_proc (
    .clk(clk), .rst(rst), .start(start),
    .hst_we(hst_we), .hst_addr(hst_addr), .hst_wdata(hst_wdata), .hst_rdata(hst_rdata),
    .halted(halted), .illegal_op(illegal_op), .acc_out(acc_out), .pc_out(pc_out)
  );

  function automatic logic [DW-1:0] w(int op, int arg);
    return {op[7:0], arg[15:0]};
  endfunction

  task automatic summary();
    $display("  Result: errors=%0d of %0d checks", n_errors, n_checks);
  endtask

  // Monitor: pops expected items and compares against the design
  initial begin
    forever begin
      @(sample_ev);
      while (src_q.size() > 0) begin
        int            s;
        logic [DW-1:0] e, a, v;
        string         t;
        s = src_q.pop_front(); e = exp_q.pop_front();
        v = act_q.pop_front(); t = tag_q.pop_front();
        case (s)
          0: a = acc_out;
          1: a = hst_rdata;
          2: a = DW'(halted);
          3: a = DW'(illegal_op);
          4: a = DW'(pc_out);
          default: a = v;
        endcase
        n_checks++;
        if (a !== e) begin
          n_errors++;
          $display("FAIL %s: actual=%h expected=%h", t, a, e);
        end
      end
    end
  end

  task automatic expect_out(int s, logic [DW-1:0] e, string t);
    src_q.push_back(s); exp_q.push_back(e); act_q.push_back('0); tag_q.push_back(t);
    -> sample_ev;
    #1;
  endtask

  task automatic expect_val(int v, int e, string t);
    src_q.push_back(9); exp_q.push_back(DW'(e)); act_q.push_back(DW'(v)); tag_q.push_back(t);
    -> sample_ev;
    #1;
  endtask

  task automatic poke(int addr, logic [DW-1:0] d);
    @(negedge clk);
    hst_we = 1'b1; hst_addr = AW'(addr); hst_wdata = d;
    @(negedge clk);
    hst_we = 1'b0;
  endtask

  task automatic peek(int addr, logic [DW-1:0] e, string t);
    @(negedge clk);
    hst_addr = AW'(addr);
    @(negedge clk);
    expect_out(1, e, t);
  endtask

  // Start a program; optionally pulse start again mid-run; returns cycles to halt
  task automatic run(input int poke_at, output int cnt);
    @(negedge clk);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    cnt = 0;
    while (!halted && cnt < RUN_LIMIT) begin
      @(negedge clk);
      cnt++;
      start = (cnt == poke_at);
    end
    start = 1'b0;
    if (cnt >= RUN_LIMIT) begin
      n_checks++; n_errors++;
      $display("FAIL run limit: actual=%0d expected<%0d", cnt, RUN_LIMIT);
    end
  endtask

  initial begin
    #(200000 * 20);
    n_checks++; n_errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    summary();
    $finish;
  end

  initial begin
    int cyc;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    expect_out(0, 24'h0, "R1 acc");
    expect_out(4, 24'd1, "R1 pc");
    expect_out(2, 24'd0, "R1 halted");
    expect_out(3, 24'd0, "R1 illegal");

    // Program A: loadi, store, add, subi below zero, halt
    poke(1, w(2, 7)); poke(2, w(3, 300)); poke(3, w(4, 300));
    poke(4, w(7, 20)); poke(5, w(0, 0));
    run(0, cyc);
    expect_val(cyc, 20, "R3 cycles for five instructions");
    expect_out(0, 24'hFFFFFA, "R5 add/sub wrap");
    expect_out(4, 24'd6, "R2 pc after halt");
    expect_out(2, 24'd1, "R2 halted set");
    peek(300, 24'd7, "R4 store via R9 host read");
    repeat (3) @(negedge clk);
    expect_out(2, 24'd1, "R2 halted holds");

    // Same program, extra start pulse mid-run must be ignored
    run(6, cyc);
    expect_val(cyc, 20, "R2 start ignored while running (cycles)");
    expect_out(0, 24'hFFFFFA, "R2 start ignored while running (acc)");

    // Program B: load, sub to zero, conditional jumps
    poke(1, w(1, 300)); poke(2, w(6, 300)); poke(3, w(9, 6));
    poke(4, w(2, 99));  poke(5, w(0, 0));   poke(6, w(10, 9));
    poke(7, w(5, 5));   poke(8, w(10, 11)); poke(9, w(2, 55));
    poke(10, w(0, 0));  poke(11, w(0, 0));
    run(0, cyc);
    expect_val(cyc, 28, "R3 cycles with jumps");
    expect_out(0, 24'd5, "R6 jz taken, jgt on zero not taken, jgt on positive taken");
    expect_out(4, 24'd12, "R6 pc after jump path");

    // Program C: negative accumulator does not take jgt
    poke(1, w(2, 0)); poke(2, w(7, 1)); poke(3, w(10, 5));
    poke(4, w(0, 0)); poke(5, w(2, 77)); poke(6, w(0, 0));
    run(0, cyc);
    expect_out(0, 24'hFFFFFF, "R6 jgt on negative not taken");
    expect_out(4, 24'd5, "R6 pc after negative");

    // Program D: jump, address wrap, zero-extended immediate
    poke(1, w(8, 4)); poke(2, w(2, 1)); poke(3, w(0, 0));
    poke(4, w(2, 16'h1234)); poke(5, w(3, 2448)); poke(6, w(2, 0));
    poke(7, w(1, 400)); poke(8, w(5, 16'hFFFF)); poke(9, w(0, 0));
    run(0, cyc);
    expect_val(cyc, 28, "R6 unconditional jump skips words");
    expect_out(0, 24'h011233, "R4 zero-extended immediate after R8 wrapped store");
    peek(400, 24'h001234, "R8 operand 2448 reaches word 400");

    // Program E: illegal opcode
    poke(1, w(2, 3)); poke(2, w(11, 0)); poke(3, w(2, 9)); poke(4, w(0, 0));
    run(0, cyc);
    expect_val(cyc, 8, "R7 stops at illegal word");
    expect_out(3, 24'd1, "R7 illegal flag");
    expect_out(0, 24'd3, "R7 acc unchanged");
    expect_out(4, 24'd3, "R7 pc");
    poke(1, w(255, 0));
    run(0, cyc);
    expect_out(3, 24'd1, "R7 opcode 255 illegal");
    poke(1, w(0, 0));
    run(0, cyc);
    expect_out(3, 24'd0, "R7 start clears illegal flag");
    expect_val(cyc, 4, "R3 lone halt takes four cycles");

    // Program F: multiply by repeated addition
    poke(1, w(1, 1000));  poke(2, w(3, 1003));  poke(3, w(2, 0));
    poke(4, w(3, 1002));  poke(5, w(1, 1003));  poke(6, w(9, 13));
    poke(7, w(7, 1));     poke(8, w(3, 1003));  poke(9, w(1, 1002));
    poke(10, w(4, 1001)); poke(11, w(3, 1002)); poke(12, w(8, 5));
    poke(13, w(0, 0));
    poke(1000, 24'd21); poke(1001, 24'd5);
    run(0, cyc);
    peek(1002, 24'd105, "R10 product 21*5");
    peek(1003, 24'd0, "R10 counter exhausted");
    poke(1000, 24'd3); poke(1001, 24'd1000);
    run(0, cyc);
    peek(1002, 24'd3000, "R10 product 3*1000");
    poke(1000, 24'd0);
    run(0, cyc);
    peek(1002, 24'd0, "R10 product with zero");

    summary();
    $finish;
  end

endmodule